// File: doc/BRIEF.md
# Watermark-Interrupt Serial Port

A register-mapped asynchronous serial transmitter and receiver. It holds an eight-byte transmit queue and an eight-byte receive queue and shares a 16-bit bit-period divisor between both directions. Frames carry eight data bits, least significant bit first, with no parity. The transmitter can append one or two stop bits. A 32-bit register bus (address, write strobe, write data, read strobe, read data) holds the data, control, interrupt and divisor registers. A single level interrupt reports queue fill levels against programmable thresholds, not individual characters.

Software pushes bytes by writing the transmit data register, and bit 31 of that register tells it when the queue is full. It drains received bytes by reading the receive data register until bit 31 reports empty. The transmitter runs the states TX_IDLE, TX_START, TX_DATA, TX_STOP1 and TX_STOP2. TX_IDLE goes to TX_START and loads a byte when transmission is enabled and the queue holds data. TX_START goes to TX_DATA after one bit period. TX_DATA goes to TX_STOP1 after the eighth data bit. TX_STOP1 goes to TX_STOP2 when two stop bits are selected, or else back to TX_IDLE. TX_STOP2 goes to TX_IDLE. The receiver runs the states RX_IDLE, RX_HALF, RX_DATA and RX_STOP. RX_IDLE goes to RX_HALF on a synchronized falling edge while reception is enabled. RX_HALF goes to RX_DATA if the line is still low half a period later, or else back to RX_IDLE. RX_DATA goes to RX_STOP after eight mid-bit samples. RX_STOP goes to RX_IDLE after the stop-bit sample, and stores the byte at that point if the stop bit is high and there is room.

Top module: `serial_port_wm`

## Requirements
- R1: After reset, the control (0x08, 0x0C), interrupt-enable (0x10) and pending (0x14) registers read 0. The divisor (0x18) reads 15. Transmit data (0x00) reads 0. Receive data (0x04) reads with bit 31 set. tx_o is high and irq_o is low.
- R2: A write to 0x00 appends bits 7:0 to the transmit queue. A read of 0x00 returns bit 31 = 1 exactly when the queue holds 8 bytes, with all other bits 0. A write to a full queue is discarded.
- R3: A frame is one low start bit, then data bits 0 through 7, then high stop bit(s). Each bit lasts divisor+1 clock cycles, where the divisor is bits 15:0 of 0x18. The line is high when no frame is in progress.
- R4: Register 0x08 holds the transmit enable in bit 0, the stop-bit select in bit 1 (0 gives one stop bit, 1 gives two) and the transmit threshold in bits 18:16. A frame starts only while bit 0 is 1.
- R5: Queued bytes go out with exactly one high cycle between the last stop bit and the next start bit. A frame in progress completes even if transmission is disabled during it.
- R6: A read of 0x04 returns the oldest received byte in bits 7:0 with bit 31 = 0 and removes that byte. When the queue is empty, the read returns bit 31 = 1 with bits 7:0 = 0 and removes nothing.
- R7: Register 0x0C holds the receive enable in bit 0 and the receive threshold in bits 18:16. A frame is stored only if reception is enabled, its stop bit is high and the queue has room. Otherwise it is discarded.
- R8: Register 0x14 reads bit 0 = (transmit count < transmit threshold) and bit 1 = (receive count > receive threshold). Writes to 0x14 have no effect.
- R9: irq_o is high exactly when some bit of 0x14 is set together with the same bit of 0x10.
- R10: A write to the transmit queue in the same cycle as the transmitter loads a byte from it takes effect, unless the queue was full before that cycle.
- R11: A low pulse on rx_i shorter than half a bit period starts no frame, and the receiver then accepts the next valid frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 5 | Byte address of the register |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_re | input | 1 | Read strobe (pops the receive queue at 0x04) |
| bus_rdata | output | 32 | Read data, combinational from address |
| tx_o | output | 1 | Serial transmit line |
| rx_i | input | 1 | Serial receive line (asynchronous) |
| irq_o | output | 1 | Level interrupt |

## Verification
The functions that can fall in the same cycle are a bus write that pushes into the transmit queue and the transmitter in TX_IDLE that pops the queue head to start a frame. The bench provokes this by writing bytes on consecutive cycles into an empty queue with transmission enabled. It also fills the queue with transmission off, enables it, and writes a ninth byte in exactly the cycle of the first load. A behavioural queue model, advanced on every clock, decides what the result should be. Each cycle, that model's expected line level and interrupt are compared with tx_o and irq_o, and register reads afterwards confirm which bytes were kept.

// File: rtl/sp_pkg.sv
`timescale 1ns/1ps
package sp_pkg;
    localparam int unsigned OFF_TXDATA = 32'h00;
    localparam int unsigned OFF_RXDATA = 32'h04;
    localparam int unsigned OFF_TXCTRL = 32'h08;
    localparam int unsigned OFF_RXCTRL = 32'h0C;
    localparam int unsigned OFF_IE     = 32'h10;
    localparam int unsigned OFF_IP     = 32'h14;
    localparam int unsigned OFF_DIV    = 32'h18;
    localparam int unsigned WM_LSB     = 16;

    typedef enum logic [2:0] {TX_IDLE, TX_START, TX_DATA, TX_STOP1, TX_STOP2} tx_state_e;
    typedef enum logic [1:0] {RX_IDLE, RX_HALF, RX_DATA, RX_STOP} rx_state_e;
endpackage

// File: rtl/sp_fifo.sv
`timescale 1ns/1ps
module sp_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 8,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int PW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_i,
    input  logic [W-1:0]  wdata_i,
    input  logic          rd_i,
    output logic [W-1:0]  rdata_o,
    output logic [CW-1:0] count_o,
    output logic          full_o,
    output logic          empty_o
);
    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] rp, wp;
    logic [CW-1:0] cnt;
    logic          wr_ok, rd_ok;

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full_o  = (cnt == CW'(DEPTH));
    assign empty_o = (cnt == '0);
    assign wr_ok   = wr_i && !full_o;
    assign rd_ok   = rd_i && !empty_o;
    assign rdata_o = mem[rp];
    assign count_o = cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rp  <= '0;
            wp  <= '0;
            cnt <= '0;
        end else begin
            if (wr_ok) wp <= step(wp);
            if (rd_ok) rp <= step(rp);
            cnt <= cnt + CW'(wr_ok) - CW'(rd_ok);
        end
    end

    always_ff @(posedge clk) begin
        if (wr_ok) mem[wp] <= wdata_i;
    end

    AST_FULL_DROPS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && full_o && !rd_i) |=> (cnt == CW'(DEPTH))); // R2
    AST_PUSH_POP_SAME: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && rd_i && !full_o && !empty_o) |=> $stable(cnt)); // R10
endmodule

// File: rtl/sp_tx.sv
`timescale 1ns/1ps
module sp_tx
    import sp_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             two_stop_i,
    input  logic [DIV_W-1:0] div_i,
    input  logic             avail_i,
    input  logic [7:0]       data_i,
    output logic             pop_o,
    output logic             tx_o
);
    tx_state_e        state, nstate;
    logic [DIV_W-1:0] cnt;
    logic [2:0]       bitn;
    logic [7:0]       sh;
    logic             tick;

    assign tick = (cnt == div_i);

    always_comb begin
        nstate = state;
        unique case (state)
            TX_IDLE:  if (en_i && avail_i) nstate = TX_START;
            TX_START: if (tick) nstate = TX_DATA;
            TX_DATA:  if (tick && bitn == 3'd7) nstate = TX_STOP1;
            TX_STOP1: if (tick) nstate = two_stop_i ? TX_STOP2 : TX_IDLE;
            TX_STOP2: if (tick) nstate = TX_IDLE;
            default:  nstate = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= TX_IDLE;
            cnt   <= '0;
            bitn  <= '0;
            sh    <= '0;
        end else begin
            state <= nstate;
            if (state == TX_IDLE) begin
                cnt  <= '0;
                bitn <= '0;
                if (pop_o) sh <= data_i;
            end else if (tick) begin
                cnt <= '0;
                if (state == TX_DATA) begin
                    sh   <= {1'b0, sh[7:1]};
                    bitn <= bitn + 3'd1;
                end
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    always_comb begin
        pop_o = (state == TX_IDLE) && en_i && avail_i;
        unique case (state)
            TX_START: tx_o = 1'b0;
            TX_DATA:  tx_o = sh[0];
            default:  tx_o = 1'b1;
        endcase
    end

    AST_LOAD_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TX_START && $past(state) == TX_IDLE) |-> $past(en_i && avail_i)); // R4
    AST_FRAME_OPENS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == TX_IDLE && state != TX_IDLE) |-> !tx_o); // R3
endmodule

// File: rtl/sp_rx.sv
`timescale 1ns/1ps
module sp_rx
    import sp_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [DIV_W-1:0] div_i,
    input  logic             rx_i,
    input  logic             full_i,
    output logic             push_o,
    output logic [7:0]       data_o
);
    rx_state_e        state, nstate;
    logic [DIV_W-1:0] cnt, half;
    logic [2:0]       bitn;
    logic [7:0]       sh;
    logic             s1, s2, prev, fall, tick;

    assign half = div_i >> 1;
    assign tick = (cnt == div_i);
    assign fall = prev && !s2;

    always_comb begin
        nstate = state;
        unique case (state)
            RX_IDLE: if (en_i && fall) nstate = RX_HALF;
            RX_HALF: if (cnt == half) nstate = s2 ? RX_IDLE : RX_DATA;
            RX_DATA: if (tick && bitn == 3'd7) nstate = RX_STOP;
            RX_STOP: if (tick) nstate = RX_IDLE;
            default: nstate = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= RX_IDLE;
            cnt   <= '0;
            bitn  <= '0;
            sh    <= '0;
            s1    <= 1'b1;
            s2    <= 1'b1;
            prev  <= 1'b1;
        end else begin
            s1    <= rx_i;
            s2    <= s1;
            prev  <= s2;
            state <= nstate;
            if (state == RX_IDLE || nstate != state || (state == RX_DATA && tick))
                cnt <= '0;
            else
                cnt <= cnt + 1'b1;
            if (state == RX_IDLE) begin
                bitn <= '0;
            end else if (state == RX_DATA && tick) begin
                sh   <= {s2, sh[7:1]};
                bitn <= bitn + 3'd1;
            end
        end
    end

    always_comb begin
        push_o = (state == RX_STOP) && tick && s2 && !full_i;
        data_o = sh;
    end

    AST_PUSH_ENDS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        push_o |=> (state == RX_IDLE)); // R7
    AST_FRAME_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RX_HALF && $past(state) == RX_IDLE) |-> $past(en_i)); // R7
endmodule

// File: rtl/serial_port_wm.sv
`timescale 1ns/1ps
module serial_port_wm
    import sp_pkg::*;
#(
    parameter int          DEPTH     = 8,
    parameter int          DIV_W     = 16,
    parameter int          WM_W      = 3,
    parameter int          ADDR_W    = 5,
    parameter int unsigned DIV_RESET = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    input  logic              bus_re,
    output logic [31:0]       bus_rdata,
    output logic              tx_o,
    input  logic              rx_i,
    output logic              irq_o
);
    localparam int CW = $clog2(DEPTH + 1);

    logic             tx_en, tx_two, rx_en;
    logic [WM_W-1:0]  tx_wm, rx_wm;
    logic [1:0]       ie, ip;
    logic [DIV_W-1:0] div;

    logic             hit_txd, hit_rxd, hit_txc, hit_rxc, hit_ie, hit_div;
    logic             tx_pop, tx_full, tx_empty, rx_push, rx_full, rx_empty, rx_pop;
    logic [7:0]       tx_head, rx_head, rx_byte;
    logic [CW-1:0]    tx_cnt, rx_cnt;
    logic             unused_hi;

    assign unused_hi = ^bus_wdata[31:WM_LSB+WM_W];

    assign hit_txd = (32'(bus_addr) == OFF_TXDATA);
    assign hit_rxd = (32'(bus_addr) == OFF_RXDATA);
    assign hit_txc = (32'(bus_addr) == OFF_TXCTRL);
    assign hit_rxc = (32'(bus_addr) == OFF_RXCTRL);
    assign hit_ie  = (32'(bus_addr) == OFF_IE);
    assign hit_div = (32'(bus_addr) == OFF_DIV);
    assign rx_pop  = bus_re && hit_rxd;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_en  <= 1'b0;
            tx_two <= 1'b0;
            tx_wm  <= '0;
            rx_en  <= 1'b0;
            rx_wm  <= '0;
            ie     <= '0;
            div    <= DIV_W'(DIV_RESET);
        end else if (bus_we) begin
            if (hit_txc) begin
                tx_en  <= bus_wdata[0];
                tx_two <= bus_wdata[1];
                tx_wm  <= bus_wdata[WM_LSB +: WM_W];
            end
            if (hit_rxc) begin
                rx_en <= bus_wdata[0];
                rx_wm <= bus_wdata[WM_LSB +: WM_W];
            end
            if (hit_ie)  ie  <= bus_wdata[1:0];
            if (hit_div) div <= bus_wdata[DIV_W-1:0];
        end
    end

    sp_fifo #(.W(8), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n),
        .wr_i(bus_we && hit_txd), .wdata_i(bus_wdata[7:0]),
        .rd_i(tx_pop), .rdata_o(tx_head), .count_o(tx_cnt),
        .full_o(tx_full), .empty_o(tx_empty)
    );

    sp_fifo #(.W(8), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n),
        .wr_i(rx_push), .wdata_i(rx_byte),
        .rd_i(rx_pop), .rdata_o(rx_head), .count_o(rx_cnt),
        .full_o(rx_full), .empty_o(rx_empty)
    );

    sp_tx #(.DIV_W(DIV_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .en_i(tx_en), .two_stop_i(tx_two),
        .div_i(div), .avail_i(!tx_empty), .data_i(tx_head),
        .pop_o(tx_pop), .tx_o(tx_o)
    );

    sp_rx #(.DIV_W(DIV_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .en_i(rx_en), .div_i(div),
        .rx_i(rx_i), .full_i(rx_full), .push_o(rx_push), .data_o(rx_byte)
    );

    assign ip[0] = (tx_cnt < CW'(tx_wm));
    assign ip[1] = (rx_cnt > CW'(rx_wm));
    assign irq_o = |(ip & ie);

    always_comb begin
        bus_rdata = '0;
        if (hit_txd) begin
            bus_rdata[31] = tx_full;
        end else if (hit_rxd) begin
            bus_rdata[31]  = rx_empty;
            bus_rdata[7:0] = rx_empty ? 8'h00 : rx_head;
        end else if (hit_txc) begin
            bus_rdata[WM_LSB +: WM_W] = tx_wm;
            bus_rdata[1]              = tx_two;
            bus_rdata[0]              = tx_en;
        end else if (hit_rxc) begin
            bus_rdata[WM_LSB +: WM_W] = rx_wm;
            bus_rdata[0]              = rx_en;
        end else if (hit_ie) begin
            bus_rdata[1:0] = ie;
        end else if (32'(bus_addr) == OFF_IP) begin
            bus_rdata[1:0] = ip;
        end else if (hit_div) begin
            bus_rdata[DIV_W-1:0] = div;
        end
    end

    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (ie != 2'b00)); // R9
    AST_RX_POP_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_cnt < $past(rx_cnt)) |-> $past(bus_re && 32'(bus_addr) == OFF_RXDATA)); // R6
endmodule

// File: tb/sim_serial_port_wm.sv
`timescale 1ns/1ps
module sim_serial_port_wm;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  addr = '0;
    logic        we = 1'b0, re = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        tx, irq;
    logic        rx = 1'b1;

    always #2 clk = ~clk;

    serial_port_wm u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we),
        .bus_wdata(wdata), .bus_re(re), .bus_rdata(rdata),
        .tx_o(tx), .rx_i(rx), .irq_o(irq)
    );

    // behavioural reference model
    logic [7:0] mtxq[$];
    logic [7:0] mrxq[$];
    logic       m_txen = 0, m_nstop = 0, m_rxen = 0;
    int         m_txwm = 0, m_rxwm = 0, m_div = 15;
    logic [1:0] m_ie = 0;
    int         phase = 0, mcnt = 0, pre_sz = 0;
    logic [7:0] mbyte = 0;

    int    n_vec = 0, n_bad = 0;
    bit    done = 0, rx_quiet = 1;
    string tag = "R3";

    always @(posedge clk) begin
        if (!rst_n) begin
            mtxq.delete(); mrxq.delete();
            m_txen = 0; m_nstop = 0; m_rxen = 0; m_txwm = 0; m_rxwm = 0;
            m_ie = 0; m_div = 15; phase = 0; mcnt = 0;
        end else begin
            pre_sz = mtxq.size();
            if (phase == 0) begin
                if (m_txen && mtxq.size() > 0) begin
                    mbyte = mtxq.pop_front(); phase = 1; mcnt = 0;
                end
            end else if (mcnt == m_div) begin
                mcnt = 0;
                if (phase < 10) phase = phase + 1;
                else if (phase == 10) phase = m_nstop ? 11 : 0;
                else phase = 0;
            end else begin
                mcnt = mcnt + 1;
            end
            if (we) begin
                case (addr)
                    5'h00: if (pre_sz < 8) mtxq.push_back(wdata[7:0]);
                    5'h08: begin m_txen = wdata[0]; m_nstop = wdata[1]; m_txwm = int'(wdata[18:16]); end
                    5'h0C: begin m_rxen = wdata[0]; m_rxwm = int'(wdata[18:16]); end
                    5'h10: m_ie = wdata[1:0];
                    5'h18: m_div = int'(wdata[15:0]);
                    default: ;
                endcase
            end
            if (re && addr == 5'h04 && mrxq.size() > 0) void'(mrxq.pop_front());
        end
    end

    function automatic logic exp_tx();
        if (phase == 0 || phase >= 10) return 1'b1;
        if (phase == 1) return 1'b0;
        return mbyte[phase-2];
    endfunction

    function automatic logic exp_irq();
        return ((mtxq.size() < m_txwm) && m_ie[0]) || ((mrxq.size() > m_rxwm) && m_ie[1]);
    endfunction

    function automatic logic [31:0] exp_rd(input logic [4:0] a);
        logic [31:0] v = '0;
        case (a)
            5'h00: v[31] = (mtxq.size() == 8);
            5'h04: begin v[31] = (mrxq.size() == 0); if (mrxq.size() > 0) v[7:0] = mrxq[0]; end
            5'h08: begin v[0] = m_txen; v[1] = m_nstop; v[18:16] = m_txwm[2:0]; end
            5'h0C: begin v[0] = m_rxen; v[18:16] = m_rxwm[2:0]; end
            5'h10: v[1:0] = m_ie;
            5'h14: begin v[0] = (mtxq.size() < m_txwm); v[1] = (mrxq.size() > m_rxwm); end
            5'h18: v[15:0] = m_div[15:0];
            default: v = '0;
        endcase
        return v;
    endfunction

    // per-clock comparison of the line and the interrupt
    always @(negedge clk) begin
        if (!done) begin
            n_vec++;
            if (tx !== exp_tx()) begin
                n_bad++;
                $display("FAIL %s tx_o got %b exp %b at %0t", tag, tx, exp_tx(), $time);
            end
            if (rx_quiet) begin
                n_vec++;
                if (irq !== exp_irq()) begin
                    n_bad++;
                    $display("FAIL R9 irq_o got %b exp %b at %0t", irq, exp_irq(), $time);
                end
            end
        end
    end

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, input string t);
        logic [31:0] e;
        addr = a; re = 1'b1;
        #1;
        e = exp_rd(a);
        n_vec++;
        if (rdata !== e) begin
            n_bad++;
            $display("FAIL %s read 0x%02h got %08h exp %08h", t, a, rdata, e);
        end
        @(negedge clk);
        re = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_tx();
        while (!(phase == 0 && mtxq.size() == 0)) @(negedge clk);
        idle(2);
    endtask

    task automatic send(input logic [7:0] b, input logic stop_ok);
        int bl = m_div + 1;
        rx_quiet = 0;
        rx = 1'b0; idle(bl);
        for (int i = 0; i < 8; i++) begin rx = b[i]; idle(bl); end
        rx = stop_ok; idle(bl);
        if (stop_ok && m_rxen && mrxq.size() < 8) mrxq.push_back(b);
        rx = 1'b1; idle(bl);
        rx_quiet = 1;
    endtask

    task automatic finish_up();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            finish_up();
        end
    end

    initial begin
        idle(4);
        rst_n = 1'b1;
        idle(1);
        // R1 reset state
        rd(5'h00, "R1"); rd(5'h04, "R1"); rd(5'h08, "R1"); rd(5'h0C, "R1");
        rd(5'h10, "R1"); rd(5'h14, "R1"); rd(5'h18, "R1");

        wr(5'h18, 32'd7);
        rd(5'h18, "R3");

        // R4: no frame while disabled
        tag = "R4";
        wr(5'h00, 32'hA5); wr(5'h00, 32'h3C); wr(5'h00, 32'h01);
        idle(40);
        rd(5'h00, "R2");
        tag = "R3";
        wr(5'h08, 32'h1);
        rd(5'h08, "R4");
        tag = "R5";
        wait_tx();

        // R2: full queue
        wr(5'h08, 32'h0);
        for (int i = 0; i < 8; i++) wr(5'h00, 32'h10 + i);
        rd(5'h00, "R2");
        wr(5'h00, 32'hEE);
        rd(5'h00, "R2");
        // R10: enable and write in the load cycle while full
        tag = "R10";
        wr(5'h08, 32'h1);
        wr(5'h00, 32'h77);
        wr(5'h00, 32'h88);
        rd(5'h00, "R10");
        wait_tx();
        // R10: back-to-back writes into an empty running queue
        for (int i = 0; i < 4; i++) wr(5'h00, 32'hC0 + 7 * i);
        rd(5'h00, "R10");
        wait_tx();

        // R4/R5: two stop bits, disable mid-frame
        tag = "R4";
        wr(5'h08, 32'h3);
        wr(5'h00, 32'h96); wr(5'h00, 32'h5B);
        idle(20);
        tag = "R5";
        wr(5'h08, 32'h2);
        idle(200);
        rd(5'h08, "R4");
        wr(5'h08, 32'h3);
        wait_tx();

        // R8/R9: transmit threshold
        tag = "R8";
        wr(5'h08, 32'h0004_0000);
        wr(5'h10, 32'h1);
        rd(5'h14, "R8");
        for (int i = 0; i < 5; i++) wr(5'h00, 32'h31 + i);
        rd(5'h14, "R8");
        wr(5'h14, 32'h0);
        rd(5'h14, "R8");
        tag = "R9";
        wr(5'h08, 32'h0004_0001);
        wait_tx();
        rd(5'h10, "R9");
        wr(5'h10, 32'h0);

        // R7: receiver disabled drops frame
        send(8'h6D, 1'b1);
        rd(5'h04, "R7");
        wr(5'h0C, 32'h0001_0001);
        wr(5'h10, 32'h2);
        rd(5'h0C, "R7");
        send(8'h5A, 1'b1);
        rd(5'h14, "R8");
        send(8'hC3, 1'b1);
        rd(5'h14, "R8");
        rd(5'h04, "R6"); rd(5'h04, "R6"); rd(5'h04, "R6");
        // R7: bad stop bit
        send(8'h99, 1'b0);
        idle(10);
        rd(5'h04, "R7");
        // R7: overflow drops ninth frame
        for (int i = 0; i < 9; i++) send(8'h20 + 8'(i * 3), 1'b1);
        for (int i = 0; i < 9; i++) rd(5'h04, "R7");

        // R11: short glitch
        rx_quiet = 0;
        rx = 1'b0; idle(2); rx = 1'b1;
        idle(40);
        rx_quiet = 1;
        rd(5'h04, "R11");
        send(8'h42, 1'b1);
        rd(5'h04, "R11");
        rd(5'h04, "R11");

        idle(5);
        finish_up();
    end
endmodule